// File: doc/BRIEF.md
# Selectable-Width CRC Checksum Unit

This unit accumulates a cyclic redundancy checksum over a sequence of bytes, in either a 16-bit mode (polynomial 0x1021, most significant bit first) or a 32-bit mode (the Ethernet polynomial, least significant bit first). A small byte-wide register interface configures it, takes processor data and exposes the result. A control bit decides where bytes come from. They can come from processor writes to a data-in register, or from a streaming port that a memory scanner drives, one byte per beat, with a marker on the final beat.

Software first loads the starting remainder, either all zeros or all ones, while the unit is disabled. It then enables the unit and selects the width and the source. In streaming mode it polls the busy flag and then reads the four checksum byte registers. In 32-bit mode the value read back is the complement of the bit-reversed internal remainder. With the all-ones start value this yields the standard CRC-32 value, and it makes the fixed residues usable for block self-checks.

Top module: `crc_engine`

## Requirements
- R1: After reset the unit is disabled, in 16-bit mode with processor source, the internal remainder is zero, busy is 0, and all four checksum registers read 0x00.
- R2: Register map (byte addresses): 0 = control (bit0 enable, bit1 32-bit mode, bit2 stream source, bit3 preset command, bit4 preset value is all ones; bits 2:0 read back, bits 3 and 4 are not stored), 1 = status (bit0 busy), 2 = data-in (write only), 4..7 = checksum byte 0 (least significant) to byte 3.
- R3: In 32-bit mode each byte is absorbed least significant bit first with the reflected polynomial 0xEDB88320, and the checksum reads as the complement of the bit-reversed remainder; "123456789" after an all-ones preset reads 0xCBF43926.
- R4: In 16-bit mode each byte is absorbed most significant bit first with polynomial 0x1021 and no final inversion; checksum bytes 0..1 hold the remainder and bytes 2..3 read 0x00. "123456789" gives 0x29B1 after an all-ones preset and 0x31C3 after an all-zeros preset.
- R5: A control write with bit3 set loads the remainder with all ones (bit4 = 1) or all zeros (bit4 = 0) only if the unit was disabled before that write; while enabled the command has no effect.
- R6: With source bit 0, a data-in write absorbs one byte and stream beats are ignored; with source bit 1, each valid stream beat absorbs one byte and data-in writes are ignored; nothing is absorbed while disabled.
- R7: One byte is absorbed per clock, and its effect is readable in the cycle after it is taken.
- R8: Busy rises in the cycle after the first accepted stream beat, stays high while beats continue, and falls one cycle after the cycle that follows the acceptance of a beat marked last.
- R9: In 32-bit mode with an all-ones preset, a message followed by its checksum in little-endian order reads 0x2144DF1C, and a message followed by the complemented checksum reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| strm_valid | input | 1 | Stream byte valid |
| strm_byte | input | 8 | Stream byte |
| strm_last | input | 1 | Marks the final stream byte |
| busy | output | 1 | Stream absorption in progress |

## Verification
A corrupted remainder shows up in the checksum registers in the very next cycle, because the readback is a pure function of the remainder. Every following byte then spreads the error through all the bits, so one wrong absorb or preset is visible at the ports on the next read. A wrong busy state appears on the status register within one cycle of the last stream beat. The fixed known-answer strings and the two residue constants check the bit ordering and the output transform, which random comparisons against a reference would also expose.

// File: rtl/crc_engine.sv
module crc_engine #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              strm_valid,
  input  logic [7:0]        strm_byte,
  input  logic              strm_last,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SUM0 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SUM1 = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_SUM2 = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_SUM3 = ADDR_W'(7);
  localparam logic [31:0] POLY32 = 32'h04C1_1DB7;
  localparam logic [15:0] POLY16 = 16'h1021;

  logic        en_q, wide_q, src_q, busy_q, tail_q;
  logic [31:0] rem_q, rem_nxt, sum;

  function automatic logic [31:0] step32(input logic [31:0] r, input logic [7:0] d);
    logic [31:0] c;
    c = r;
    for (int i = 0; i < 8; i++)
      c = {c[30:0], 1'b0} ^ ((c[31] ^ d[i]) ? POLY32 : 32'h0);
    return c;
  endfunction

  function automatic logic [15:0] step16(input logic [15:0] r, input logic [7:0] d);
    logic [15:0] c;
    c = r;
    for (int i = 7; i >= 0; i--)
      c = {c[14:0], 1'b0} ^ ((c[15] ^ d[i]) ? POLY16 : 16'h0);
    return c;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] o;
    for (int i = 0; i < 32; i++) o[i] = v[31-i];
    return o;
  endfunction

  wire       ctrl_we = reg_we && reg_addr == A_CTRL;
  wire       din_we  = reg_we && reg_addr == A_DIN;
  wire       take_io = en_q && !src_q && din_we;
  wire       take_st = en_q && src_q && strm_valid;
  wire       take    = take_io || take_st;
  wire [7:0] in_byte = src_q ? strm_byte : reg_wdata;
  wire       preset  = ctrl_we && reg_wdata[3] && !en_q;

  assign rem_nxt = wide_q ? step32(rem_q, in_byte)
                          : {16'h0, step16(rem_q[15:0], in_byte)};
  assign sum     = wide_q ? ~rev32(rem_q) : {16'h0, rem_q[15:0]};
  assign busy    = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      wide_q <= 1'b0;
      src_q  <= 1'b0;
    end else if (ctrl_we) begin
      en_q   <= reg_wdata[0];
      wide_q <= reg_wdata[1];
      src_q  <= reg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (preset) rem_q <= {32{reg_wdata[4]}};
    else if (take)   rem_q <= rem_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tail_q <= 1'b0;
    end else begin
      tail_q <= take_st && strm_last;
      if (take_st)     busy_q <= 1'b1;
      else if (tail_q) busy_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {5'b0, src_q, wide_q, en_q};
      A_STAT:  reg_rdata = {7'b0, busy_q};
      A_SUM0:  reg_rdata = sum[7:0];
      A_SUM1:  reg_rdata = sum[15:8];
      A_SUM2:  reg_rdata = sum[23:16];
      A_SUM3:  reg_rdata = sum[31:24];
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

module crc_engine_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input logic              wide_q,
  input logic              src_q,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              strm_valid,
  input logic              busy,
  input logic [31:0]       rem_q
);
  wire io_wr  = reg_we && reg_addr == ADDR_W'(2);
  wire st_act = en_q && src_q && strm_valid;
  wire io_act = en_q && !src_q && io_wr;

  assert_enabled_no_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !st_act && !io_act) |=> $stable(rem_q));

  assert_disabled_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !(reg_we && reg_addr == ADDR_W'(0) && reg_wdata[3])) |=> $stable(rem_q));

  assert_busy_rises_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_act |=> busy);

  assert_busy_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !st_act) |=> !busy);

  assert_zero_rem_reads_ff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_q && rem_q == 32'h0 && reg_addr == ADDR_W'(4)) |-> reg_rdata == 8'hFF);
endmodule

bind crc_engine crc_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .wide_q(wide_q), .src_q(src_q),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .strm_valid(strm_valid), .busy(busy), .rem_q(rem_q));

// File: tb/sim_crc_engine.sv
module sim_crc_engine;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 3;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, strm_valid = 0, strm_last = 0, busy;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata, strm_byte = '0;
  int n_chk = 0, n_fail = 0;
  logic [7:0] msg[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_engine #(.ADDR_W(ADDR_W)) u0 (.*);

  function automatic logic [31:0] ref32(input logic [7:0] m[$], input bit ones);
    logic [31:0] c = ones ? 32'hFFFF_FFFF : 32'h0;
    foreach (m[k]) begin
      c ^= {24'h0, m[k]};
      for (int i = 0; i < 8; i++) c = c[0] ? (c >> 1) ^ 32'hEDB8_8320 : c >> 1;
    end
    return ~c;
  endfunction

  function automatic logic [15:0] ref16(input logic [7:0] m[$], input bit ones);
    logic [15:0] c = ones ? 16'hFFFF : 16'h0;
    foreach (m[k]) begin
      c ^= {m[k], 8'h0};
      for (int i = 0; i < 8; i++) c = c[15] ? (c << 1) ^ 16'h1021 : c << 1;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = ADDR_W'(a);
    #1 d = reg_rdata;
  endtask

  task automatic rd_sum(output logic [31:0] s);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin rd(4 + i, b); s[8*i +: 8] = b; end
  endtask

  task automatic setup(input bit wide, input bit ones, input bit src);
    wr(0, 8'h00);
    wr(0, {3'b0, ones, 1'b1, 3'b000});
    wr(0, {5'b0, src, wide, 1'b1});
  endtask

  task automatic feed(input logic [7:0] m[$], input bit src);
    if (!src) foreach (m[k]) wr(2, m[k]);
    else begin
      foreach (m[k]) begin
        @(negedge clk);
        strm_valid = 1; strm_byte = m[k]; strm_last = (k == m.size() - 1);
      end
      @(negedge clk);
      strm_valid = 0; strm_last = 0;
    end
  endtask

  task automatic run(input logic [7:0] m[$], input bit wide, input bit ones,
                     input bit src, output logic [31:0] s);
    logic [7:0] st;
    setup(wide, ones, src);
    feed(m, src);
    if (src) begin
      rd(1, st);
      while (st[0]) rd(1, st);
    end
    rd_sum(s);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] s, c;
    logic [7:0] b;
    logic [7:0] num[$];
    void'($urandom(32'd20240611));
    num = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39};
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd_sum(s);  chk("R1 checksum after reset", s, 32'h0);
    rd(1, b);   chk("R1 busy after reset", {24'h0, b}, 32'h0);
    rd(0, b);   chk("R1 control after reset", {24'h0, b}, 32'h0);

    run(num, 1, 1, 0, s); chk("R3 crc32 known answer io", s, 32'hCBF4_3926);
    run(num, 1, 1, 1, s); chk("R3 crc32 known answer stream", s, 32'hCBF4_3926);
    rd(0, b);   chk("R2 control readback", {24'h0, b}, 32'h7);
    run(num, 0, 1, 0, s); chk("R4 crc16 ones preset", s, 32'h0000_29B1);
    run(num, 0, 0, 1, s); chk("R4 crc16 zeros preset", s, 32'h0000_31C3);

    setup(1, 0, 0);
    wr(0, 8'h1B);
    rd_sum(s);  chk("R5 preset ignored while enabled", s, 32'hFFFF_FFFF);
    wr(0, 8'h00); wr(0, 8'h18); wr(0, 8'h03);
    rd_sum(s);  chk("R5 preset honoured while disabled", s, 32'h0);

    wr(0, 8'h02); wr(2, 8'hA5);
    rd_sum(s);  chk("R6 data-in ignored when disabled", s, 32'h0);
    wr(0, 8'h03); feed(num, 1);
    rd_sum(s);  chk("R6 stream ignored in io mode", s, 32'h0);
    rd(1, b);   chk("R6 no busy in io mode", {24'h0, b}, 32'h0);
    wr(0, 8'h07); wr(2, 8'h5A);
    rd_sum(s);  chk("R6 data-in ignored in stream mode", s, 32'h0);

    setup(1, 1, 0);
    wr(2, 8'h31);
    rd_sum(s);  chk("R7 one byte absorbed", s, ref32('{8'h31}, 1));

    setup(1, 1, 1);
    @(negedge clk); strm_valid = 1; strm_byte = 8'h31; strm_last = 0;
    @(negedge clk); strm_byte = 8'h32;
    #1 chk("R8 busy high mid stream", {31'h0, busy}, 32'h1);
    @(negedge clk); strm_valid = 0;
    #1 chk("R8 busy holds across gap", {31'h0, busy}, 32'h1);
    @(negedge clk); strm_valid = 1; strm_byte = 8'h33; strm_last = 1;
    @(negedge clk); strm_valid = 0; strm_last = 0;
    #1 chk("R8 busy one cycle after last", {31'h0, busy}, 32'h1);
    @(negedge clk);
    #1 chk("R8 busy cleared", {31'h0, busy}, 32'h0);
    rd_sum(s);  chk("R7 streamed bytes back to back", s, ref32('{8'h31,8'h32,8'h33}, 1));

    for (int t = 0; t < 4; t++) begin
      msg.delete();
      for (int i = 0; i < 1 + ($urandom % 12); i++) msg.push_back(8'($urandom));
      c = ref32(msg, 1);
      for (int i = 0; i < 4; i++) msg.push_back(c[8*i +: 8]);
      run(msg, 1, 1, t[0], s); chk("R9 residue with checksum", s, 32'h2144_DF1C);
      for (int i = 0; i < 4; i++) msg[msg.size() - 4 + i] = ~c[8*i +: 8];
      run(msg, 1, 1, t[0], s); chk("R9 residue with complement", s, 32'hFFFF_FFFF);
    end

    for (int t = 0; t < 24; t++) begin
      bit wide = 1'($urandom), ones = 1'($urandom), src = 1'($urandom);
      msg.delete();
      for (int i = 0; i < 1 + ($urandom % 20); i++) msg.push_back(8'($urandom));
      run(msg, wide, ones, src, s);
      if (wide) chk("R3 random crc32", s, ref32(msg, ones));
      else      chk("R4 random crc16", s, {16'h0, ref16(msg, ones)});
    end

    finish_run();
  end
endmodule